// File: doc/BRIEF.md
# Windowed Register File Controller

This block is a register file for a processor. Most of its physical registers are grouped into overlapping windows, and only one window is visible at any time. A program addresses 32 logical registers. Eight of them are globals that look the same from every window. The other 24 are translated through a current-window pointer into a larger physical array of 8 + 16·NWIN registers. The file has two combinational read ports and one write port that writes on the clock edge.

A call strobe moves the pointer one window down and a return strobe moves it one window up. The pointer wraps modulo NWIN. The outgoing-argument registers of a caller are the same storage as the incoming-argument registers of the callee, so arguments and results pass between routines without any copy. A per-window mask records which windows hold live data. When a move would reach a window that is already live (overflow) or would return into one that is empty (underflow), the block refuses the move and raises a flag. An external handler then spills or refills the windows and retries.

Top module: `rw_regfile`

## Requirements
- R1: After a synchronous active-low reset, `cwp` is 0 and `wmask` is 8'b0000_0001. Bit k of `wmask` stands for window k.
- R2: Logical registers 1 to 7 are globals. The same value is read back from them whatever the current window is.
- R3: Logical register 0 always reads 0 on both ports, and a write to it has no effect.
- R4: Logical registers 8 to 15 (outs) of window w are the same storage as logical registers 24 to 31 (ins) of window (w−1) mod NWIN.
- R5: Logical registers 16 to 23 (locals) are private to their window. Reads are combinational, and a write becomes visible in the cycle after its clock edge.
- R6: Take a call when the mask bit of window (w−1) mod NWIN is clear. The pointer becomes that window and its mask bit is set.
- R7: Take a call when the mask bit of window (w−1) mod NWIN is already set. `ovf` is high in that same cycle, and neither the pointer nor the mask changes.
- R8: Take a return when the mask bit of window (w+1) mod NWIN is set. The mask bit of window w is cleared and the pointer becomes w+1.
- R9: Take a return when the mask bit of window (w+1) mod NWIN is clear. `unf` is high in that same cycle, and neither the pointer nor the mask changes.
- R10: A write issued in the same cycle as a call or a return is translated through the window that was current before the move.
- R11: A call and a return asserted together do nothing. The pointer and the mask are unchanged, and both flags stay low.
- R12: While no strobe is asserted, `ovf` and `unf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Logical register for read port A |
| rd_a_data | output | XLEN | Read port A data (combinational) |
| rd_b_idx | input | 5 | Logical register for read port B |
| rd_b_data | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register to write |
| wr_data | input | XLEN | Write data |
| call_req | input | 1 | Move the window down by one |
| ret_req | input | 1 | Move the window up by one |
| cwp | output | log2(NWIN) | Current window pointer |
| wmask | output | NWIN | Live-window mask |
| ovf | output | 1 | Call refused: target window is live |
| unf | output | 1 | Return refused: caller window is empty |

## Verification
Overflow is the hardest condition to reach from the ports. It occurs only after NWIN−1 calls in a row with no return in between, and random strobes almost never build a chain that long. The stimulus therefore walks the pointer through every window on purpose, wrapping from 0 to NWIN−1. It then issues one more call and checks that the call is refused. After that it unwinds the whole chain until a return underflows. The same directed walk passes a value down through an out register, reads it back as an in register, and returns a result the other way. This exercises the window overlap in both directions.

// File: rtl/regwin_pkg.sv
// Shared constants and types for the windowed register file.
// Assumes four visible segments of GRP registers each; GRP is a power of two.
package regwin_pkg;
    localparam int GRP = 8;
    localparam int OFFW = $clog2(GRP);
    localparam int LW = $clog2(4 * GRP);

    typedef enum logic [1:0] {
        SEG_GLOBAL = 2'd0,
        SEG_OUT    = 2'd1,
        SEG_LOCAL  = 2'd2,
        SEG_IN     = 2'd3
    } seg_e;
endpackage

// File: rtl/rw_map.sv
// Translates a logical register number into a physical index.
// Assumes NWIN is a power of two so the window arithmetic wraps naturally.
// Physical layout: GRP globals, then for each window GRP locals followed by GRP ins.
module rw_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int PW   = 8
) (
    input  logic [LW-1:0] lidx,
    input  logic [WW-1:0] cur,
    output logic [PW-1:0] pidx,
    output logic          is_zero
);
    localparam int WSPAN = 2 * GRP;

    seg_e          seg;
    logic [WW-1:0] prev;
    int            off;

    // Segment decode and window-relative offset computation.
    always_comb begin
        seg     = seg_e'(lidx[LW-1 -: 2]);
        off     = int'(lidx[OFFW-1:0]);
        prev    = cur - 1'b1;
        is_zero = (lidx == '0);
        unique case (seg)
            SEG_GLOBAL: pidx = PW'(off);
            SEG_OUT:    pidx = PW'(GRP + int'(prev) * WSPAN + GRP + off);
            SEG_LOCAL:  pidx = PW'(GRP + int'(cur) * WSPAN + off);
            default:    pidx = PW'(GRP + int'(cur) * WSPAN + GRP + off);
        endcase
    end
endmodule

// File: rtl/rw_winctl.sv
// Window pointer and live-window mask, with overflow/underflow detection.
// Assumes NWIN is a power of two. Flags are combinational on the strobes.
module rw_winctl #(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_req,
    input  logic            ret_req,
    output logic [WW-1:0]   cwp,
    output logic [NWIN-1:0] wmask,
    output logic            ovf,
    output logic            unf
);
    logic [WW-1:0] dn;
    logic [WW-1:0] up;
    logic          do_call;
    logic          do_ret;

    // Neighbour windows and refusal conditions.
    always_comb begin
        dn      = cwp - 1'b1;
        up      = cwp + 1'b1;
        do_call = call_req && !ret_req;
        do_ret  = ret_req && !call_req;
        ovf     = do_call && wmask[dn];
        unf     = do_ret && !wmask[up];
    end

    // Pointer and mask update on accepted moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp   <= '0;
            wmask <= NWIN'(1);
        end else if (do_call && !ovf) begin
            cwp       <= dn;
            wmask[dn] <= 1'b1;
        end else if (do_ret && !unf) begin
            wmask[cwp] <= 1'b0;
            cwp        <= up;
        end
    end
endmodule

// File: rtl/rw_store.sv
// Physical register array: NRD combinational read ports and one write port.
// Assumes the caller has already suppressed writes to the zero register.
// The array has no reset; only written entries are meaningful.
module rw_store #(
    parameter int NPHYS = 136,
    parameter int PW    = $clog2(NPHYS),
    parameter int XLEN  = 32,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [PW-1:0]             wa,
    input  logic [XLEN-1:0]           wd,
    input  logic [NRD-1:0][PW-1:0]    ra,
    input  logic [NRD-1:0]            rz,
    output logic [NRD-1:0][XLEN-1:0]  rd
);
    logic [XLEN-1:0] regs [NPHYS];

    // Write port, lands on the rising edge.
    always_ff @(posedge clk) begin
        if (we) begin
            regs[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational read, forced to zero for logical register 0.
        always_comb begin
            rd[p] = rz[p] ? '0 : regs[ra[p]];
        end
    end
endmodule

// File: rtl/rw_regfile.sv
// Top level of the windowed register file.
// Ports 0 and 1 of the mapper bank serve the reads, port 2 serves the write.
// A write uses the window current before any move in the same cycle.
module rw_regfile
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int WW    = $clog2(NWIN),
    localparam int NPHYS = GRP + 2 * GRP * NWIN,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [LW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [LW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            call_req,
    input  logic            ret_req,
    output logic [WW-1:0]   cwp,
    output logic [NWIN-1:0] wmask,
    output logic            ovf,
    output logic            unf
);
    localparam int NMAP = 3;

    logic [NMAP-1:0][LW-1:0] lidx;
    logic [NMAP-1:0][PW-1:0] pidx;
    logic [NMAP-1:0]         zero;
    logic [1:0][XLEN-1:0]    rdat;
    logic                    wr_go;

    // Gather logical indices and gate writes to register 0.
    always_comb begin
        lidx[0]   = rd_a_idx;
        lidx[1]   = rd_b_idx;
        lidx[2]   = wr_idx;
        wr_go     = wr_en && !zero[2];
        rd_a_data = rdat[0];
        rd_b_data = rdat[1];
    end

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        rw_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map (
            .lidx    (lidx[m]),
            .cur     (cwp),
            .pidx    (pidx[m]),
            .is_zero (zero[m])
        );
    end

    rw_winctl #(.NWIN(NWIN), .WW(WW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .cwp      (cwp),
        .wmask    (wmask),
        .ovf      (ovf),
        .unf      (unf)
    );

    rw_store #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN), .NRD(2)) u_store (
        .clk (clk),
        .we  (wr_go),
        .wa  (pidx[2]),
        .wd  (wr_data),
        .ra  (pidx[1:0]),
        .rz  (zero[1:0]),
        .rd  (rdat)
    );
endmodule

// File: rtl/rw_regfile_chk.sv
// Property checker for the windowed register file, attached by bind.
module rw_regfile_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int WW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic [4:0]      rd_b_idx,
    input logic [XLEN-1:0] rd_b_data,
    input logic            call_req,
    input logic            ret_req,
    input logic [WW-1:0]   cwp,
    input logic [NWIN-1:0] wmask,
    input logic            ovf,
    input logic            unf
);
    typedef logic [WW-1:0] ptr_t;

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ($stable(cwp) && $stable(wmask)));
    p_unf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> ($stable(cwp) && $stable(wmask)));
    p_call_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !ovf) |=> (cwp == ptr_t'($past(cwp) - 1'b1)));
    p_ret_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && !unf) |=> (cwp == ptr_t'($past(cwp) + 1'b1)));
    p_both_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> ($stable(cwp) && $stable(wmask)));
    p_quiet_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |-> (!ovf && !unf));
    p_zero_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_idx == 5'd0) |-> (rd_a_data == '0)) and ((rd_b_idx == 5'd0) |-> (rd_b_data == '0)));
    p_live_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wmask) >= 1));
endmodule

bind rw_regfile rw_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .cwp       (cwp),
    .wmask     (wmask),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/sim_rw_regfile.sv
module sim_rw_regfile;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N = 8;
    localparam int NP = 8 + 16 * N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic [2:0]  cwp;
    logic [7:0]  wmask;
    logic        ovf, unf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state.
    int          m_w;
    logic [7:0]  m_mask;
    logic [31:0] m_val [NP];
    bit          m_known [NP];

    always #4 clk = ~clk;

    rw_regfile #(.NWIN(N), .XLEN(32)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int phys_of(input int idx, input int w);
        if (idx < 8) return idx;
        if (idx < 16) return 8 + 16 * ((w + N - 1) % N) + 8 + (idx - 8);
        if (idx < 24) return 8 + 16 * w + (idx - 16);
        return 8 + 16 * w + 8 + (idx - 24);
    endfunction

    function automatic string tag_of(input int idx);
        if (idx == 0) return "R3";
        if (idx < 8) return "R2";
        if (idx >= 16 && idx < 24) return "R5";
        return "R4";
    endfunction

    task automatic rd_chk(input int idx, input logic [31:0] act);
        int p;
        if (idx == 0) begin
            chk("R3", act, 32'd0);
        end else begin
            p = phys_of(idx, m_w);
            if (m_known[p]) chk(tag_of(idx), act, m_val[p]);
        end
    endtask

    // One clock of stimulus: drive at negedge, compare, advance the model.
    task automatic step(input int ra, input int rb, input bit we, input int wi,
                        input logic [31:0] wd, input bit c, input bit r);
        bit eo, eu;
        int tgt;
        @(negedge clk);
        rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        wr_en = we; wr_idx = 5'(wi); wr_data = wd;
        call_req = c; ret_req = r;
        #1;
        eo = c && !r && m_mask[(m_w + N - 1) % N];
        eu = r && !c && !m_mask[(m_w + 1) % N];
        chk((c && r) ? "R11" : (c ? "R7" : "R12"), 32'(ovf), 32'(eo));
        chk((c && r) ? "R11" : (r ? "R9" : "R12"), 32'(unf), 32'(eu));
        chk("R6", 32'(cwp), 32'(m_w));
        chk("R8", 32'(wmask), 32'(m_mask));
        rd_chk(ra, rd_a_data);
        rd_chk(rb, rd_b_data);
        // Model update: write first through the pre-move window (R10).
        if (we && wi != 0) begin
            m_val[phys_of(wi, m_w)] = wd;
            m_known[phys_of(wi, m_w)] = 1'b1;
        end
        if (c && !r && !eo) begin
            tgt = (m_w + N - 1) % N;
            m_mask[tgt] = 1'b1;
            m_w = tgt;
        end else if (r && !c && !eu) begin
            m_mask[m_w] = 1'b0;
            m_w = (m_w + 1) % N;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) m_known[i] = 1'b0;
        m_w = 0;
        m_mask = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 32'(cwp), 32'd0);
        chk("R1", 32'(wmask), 32'h01);
        rst_n = 1'b1;

        // Globals and zero register.
        step(0, 0, 1, 3, 32'h0000_0333, 0, 0);
        step(0, 3, 1, 0, 32'hdead_beef, 0, 0);
        step(0, 3, 0, 0, 0, 0, 0);
        chk("R3", rd_a_data, 32'd0);
        chk("R2", rd_b_data, 32'h0000_0333);
        // Return at reset has no live caller: underflow.
        step(3, 0, 0, 0, 0, 0, 1);
        chk("R9", 32'(unf), 32'd1);

        // Argument passing: write out register during the call itself (R10).
        step(0, 0, 1, 16, 32'h1111_0000, 0, 0);
        step(0, 0, 1, 8, 32'haaaa_0008, 1, 0);
        step(24, 16, 0, 0, 0, 0, 0);
        chk("R10", rd_a_data, 32'haaaa_0008);
        chk("R5", 32'(cwp), 32'd7);
        step(3, 0, 1, 26, 32'hbbbb_0026, 0, 1);
        step(10, 16, 0, 0, 0, 0, 0);
        chk("R4", rd_a_data, 32'hbbbb_0026);
        chk("R5", rd_b_data, 32'h1111_0000);

        // Walk the full chain to overflow, with globals read in each window.
        for (int k = 0; k < N - 1; k++) begin
            step(3, 0, 1, 17, 32'(k), 1, 0);
        end
        step(3, 17, 0, 0, 0, 1, 0);
        chk("R7", 32'(ovf), 32'd1);
        chk("R7", 32'(wmask), 32'hff);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R7", 32'(cwp), 32'd1);
        step(0, 0, 0, 0, 0, 1, 1);
        for (int k = 0; k < N - 1; k++) begin
            step(17, 24, 0, 0, 0, 0, 1);
        end
        step(17, 3, 0, 0, 0, 0, 1);
        chk("R9", 32'(unf), 32'd1);

        // Random traffic.
        for (int k = 0; k < 4000; k++) begin
            int s;
            s = int'($urandom_range(0, 9));
            step(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), $urandom,
                 (s < 2) || (s == 9), (s >= 2 && s < 4) || (s == 9));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule